// File: doc/BRIEF.md
# Flash Security Backdoor Unlock Controller

This block holds the memory security state of a small microcontroller. After every reset it walks a fixed set of nonvolatile bytes through a synchronous read port. It copies the 8-byte comparison key, the fine-trim byte, the oscillator-trim byte, the protection byte and the option byte into working registers. It then decides whether the device starts secure or unsecure. The option byte governs this decision: its two low bits form the security field, and its top bit enables the key.

While the device is secure and the key is enabled, code running on the CPU can write eight key bytes in sequence to temporarily lift security. A full match opens the device until the next reset. A mismatch locks out further attempts until the next reset. Writes tagged as coming from the debug port are never counted. A completed mass erase opens the device whatever the key state. The block does not perform flash programming or the erase algorithm.

The controller is a single state machine with these states:
- `ST_FETCH`: issue a read.
- `ST_CAPTURE`: store the returned byte.
- `ST_DECIDE`: evaluate the option byte.
- `ST_LOCKED`: secure, with key entry accepted.
- `ST_LOCKOUT`: secure, with key entry refused.
- `ST_OPEN`: unsecure.

Its transitions are:
- `ST_FETCH`→`ST_CAPTURE` always.
- `ST_CAPTURE`→`ST_FETCH` while bytes remain, and `ST_CAPTURE`→`ST_DECIDE` after the last one.
- `ST_DECIDE`→`ST_LOCKED` when secure with the key enabled, →`ST_LOCKOUT` when secure with the key disabled, and →`ST_OPEN` when unsecure.
- `ST_LOCKED`→`ST_OPEN` on a match or an erase, and `ST_LOCKED`→`ST_LOCKOUT` on a mismatch.
- `ST_LOCKOUT`→`ST_OPEN` on an erase.
- `ST_OPEN` is held until reset.

Top module: `flash_sec_ctrl`

## Requirements
- R1: After reset the block reads nonvolatile offsets 0 to 11 from NV_BASE, one read every two cycles, with read data returned the cycle after `rd_en`. Offsets 0-7 hold the key, 8 fine trim, 9 trim, 10 protection and 11 option. It then raises `boot_done`, and `prot_q`/`opt_q` equal the bytes stored at offsets 10 and 11.
- R2: With `dbg_mode` low during boot, `trim_q` equals the stored trim byte. With `dbg_mode` high it equals 0x80.
- R3: `ftrim_q` bit 0 equals bit 0 of the stored fine-trim byte, and bits 7:1 read zero.
- R4: `secure` is 1 in reset and throughout boot. After boot it is 1 only if option bits [1:0] equal 2'b01, and every other encoding gives 0.
- R5: When the device is secure and option bit 7 is 1, eight CPU key writes (`key_dbg`=0) whose bytes equal stored offsets 0..7 in that order clear `secure`.
- R6: A sequence of eight CPU key writes with any byte wrong leaves `secure` at 1. Later correct sequences then have no effect until reset.
- R7: Key writes with `key_dbg`=1 are ignored. They neither count toward the eight bytes nor cause a lockout.
- R8: When option bit 7 is 0, key writes of any source have no effect on `secure`.
- R9: A pulse on `erase_done` after boot clears `secure`, including when the key is disabled or locked out.
- R10: If `erase_done` coincides with the eighth key byte, `secure` is cleared whether the key matches or not.
- R11: Once cleared after boot, `secure` stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_mode | input | 1 | Debug mode; selects the default trim at boot |
| rd_en | output | 1 | Nonvolatile read request |
| rd_addr | output | ADDR_W | Nonvolatile read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| key_wr | input | 1 | Key byte write strobe |
| key_dbg | input | 1 | Write source: 1 = debug port, 0 = CPU |
| key_data | input | 8 | Key byte |
| erase_done | input | 1 | Mass erase completed pulse |
| boot_done | output | 1 | Nonvolatile loading finished |
| secure | output | 1 | Security engaged |
| prot_q | output | 8 | Working protection register |
| opt_q | output | 8 | Working option register |
| trim_q | output | 8 | Oscillator trim register |
| ftrim_q | output | 8 | Fine trim register (bit 0 only) |

## Verification
Two events can land in the same cycle: the comparator finishing on the eighth key byte, and a mass-erase completion. The bench raises `erase_done` in the very cycle that carries the eighth byte, once with a wrong key and once with the correct key. In both cases it expects `secure` to read 0 a few cycles later and to stay 0. A wrong compare result that arrives one cycle after the erase must not push the state back into lockout.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_CAPTURE,
        ST_DECIDE,
        ST_LOCKED,
        ST_LOCKOUT,
        ST_OPEN
    } sec_state_e;

    localparam logic [7:0] TRIM_DEBUG_DEFAULT = 8'h80;
    localparam logic [1:0] SEC_CODE           = 2'b01;
    localparam int unsigned KEYEN_BIT         = 7;

endpackage

// File: rtl/fsc_nv_loader.sv
module fsc_nv_loader #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned KEY_LEN = 8,
    parameter logic [ADDR_W-1:0] NV_BASE = 16'hFF80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch,
    input  logic                  capture,
    input  logic                  dbg_mode,
    input  logic [7:0]            rd_data,
    output logic                  rd_en,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  last_step,
    output logic [KEY_LEN*8-1:0]  key_flat,
    output logic [7:0]            prot_q,
    output logic [7:0]            opt_q,
    output logic [7:0]            trim_q,
    output logic [7:0]            ftrim_q
);
    import fsc_pkg::*;

    localparam int unsigned STEPS  = KEY_LEN + 4;
    localparam int unsigned STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] S_FTRIM = STEP_W'(KEY_LEN);
    localparam logic [STEP_W-1:0] S_TRIM  = STEP_W'(KEY_LEN + 1);
    localparam logic [STEP_W-1:0] S_PROT  = STEP_W'(KEY_LEN + 2);
    localparam logic [STEP_W-1:0] S_OPT   = STEP_W'(KEY_LEN + 3);

    logic [STEP_W-1:0] step;

    assign rd_en     = fetch;
    assign rd_addr   = NV_BASE + ADDR_W'(step);
    assign last_step = (step == S_OPT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step <= '0;
        end else if (capture && !last_step) begin
            step <= step + 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < KEY_LEN; i++) begin : g_key
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    key_flat[i*8 +: 8] <= 8'h00;
                end else if (capture && step == STEP_W'(i)) begin
                    key_flat[i*8 +: 8] <= rd_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ftrim_q <= 8'h00;
            trim_q  <= TRIM_DEBUG_DEFAULT;
            prot_q  <= 8'h00;
            opt_q   <= 8'h00;
        end else if (capture) begin
            if (step == S_FTRIM) ftrim_q <= {7'b0, rd_data[0]};
            if (step == S_TRIM)  trim_q  <= dbg_mode ? TRIM_DEBUG_DEFAULT : rd_data;
            if (step == S_PROT)  prot_q  <= rd_data;
            if (step == S_OPT)   opt_q   <= rd_data;
        end
    end

endmodule

// File: rtl/fsc_key_cmp.sv
module fsc_key_cmp #(
    parameter int unsigned KEY_LEN = 8,
    localparam int unsigned CNT_W  = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic [7:0]            byte_in,
    input  logic [KEY_LEN*8-1:0]  key_flat,
    output logic [CNT_W-1:0]      entry_cnt,
    output logic                  done_q,
    output logic                  match_q
);
    logic       miss;
    logic [7:0] expect_byte;
    logic       byte_bad;
    logic       is_last;

    assign expect_byte = key_flat[entry_cnt*8 +: 8];
    assign byte_bad    = (byte_in != expect_byte);
    assign is_last     = (entry_cnt == CNT_W'(KEY_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_cnt <= '0;
            miss      <= 1'b0;
            done_q    <= 1'b0;
            match_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (is_last) begin
                    entry_cnt <= '0;
                    miss      <= 1'b0;
                    done_q    <= 1'b1;
                    match_q   <= !(miss || byte_bad);
                end else begin
                    entry_cnt <= entry_cnt + 1'b1;
                    miss      <= miss || byte_bad;
                end
            end
        end
    end

endmodule

// File: rtl/fsc_ctrl_fsm.sv
module fsc_ctrl_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       last_step,
    input  logic [1:0] sec_field,
    input  logic       key_en,
    input  logic       erase_done,
    input  logic       key_done,
    input  logic       key_match,
    input  logic       key_wr,
    input  logic       key_dbg,
    output logic       fetch,
    output logic       capture,
    output logic       boot_done,
    output logic       secure,
    output logic       accept
);
    import fsc_pkg::*;

    sec_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_FETCH:   state_n = ST_CAPTURE;
            ST_CAPTURE: state_n = last_step ? ST_DECIDE : ST_FETCH;
            ST_DECIDE: begin
                if (sec_field != SEC_CODE) state_n = ST_OPEN;
                else if (key_en)           state_n = ST_LOCKED;
                else                       state_n = ST_LOCKOUT;
            end
            ST_LOCKED: begin
                if (erase_done)    state_n = ST_OPEN;
                else if (key_done) state_n = key_match ? ST_OPEN : ST_LOCKOUT;
            end
            ST_LOCKOUT: if (erase_done) state_n = ST_OPEN;
            ST_OPEN:    state_n = ST_OPEN;
        endcase
    end

    always_comb begin
        fetch     = 1'b0;
        capture   = 1'b0;
        boot_done = 1'b0;
        secure    = 1'b1;
        accept    = 1'b0;
        unique case (state)
            ST_FETCH:   fetch = 1'b1;
            ST_CAPTURE: capture = 1'b1;
            ST_DECIDE:  ;
            ST_LOCKED: begin
                boot_done = 1'b1;
                accept    = key_wr && !key_dbg;
            end
            ST_LOCKOUT: boot_done = 1'b1;
            ST_OPEN: begin
                boot_done = 1'b1;
                secure    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flash_sec_ctrl.sv
module flash_sec_ctrl #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned KEY_LEN = 8,
    parameter logic [ADDR_W-1:0] NV_BASE = 16'hFF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic              key_wr,
    input  logic              key_dbg,
    input  logic [7:0]        key_data,
    input  logic              erase_done,
    output logic              boot_done,
    output logic              secure,
    output logic [7:0]        prot_q,
    output logic [7:0]        opt_q,
    output logic [7:0]        trim_q,
    output logic [7:0]        ftrim_q
);
    import fsc_pkg::*;

    localparam int unsigned CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

    logic                 fetch, capture, last_step, accept;
    logic                 key_done, key_match;
    logic [CNT_W-1:0]     key_cnt;
    logic [KEY_LEN*8-1:0] key_flat;

    fsc_nv_loader #(
        .ADDR_W  (ADDR_W),
        .KEY_LEN (KEY_LEN),
        .NV_BASE (NV_BASE)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch     (fetch),
        .capture   (capture),
        .dbg_mode  (dbg_mode),
        .rd_data   (rd_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .last_step (last_step),
        .key_flat  (key_flat),
        .prot_q    (prot_q),
        .opt_q     (opt_q),
        .trim_q    (trim_q),
        .ftrim_q   (ftrim_q)
    );

    fsc_key_cmp #(
        .KEY_LEN (KEY_LEN)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .byte_in   (key_data),
        .key_flat  (key_flat),
        .entry_cnt (key_cnt),
        .done_q    (key_done),
        .match_q   (key_match)
    );

    fsc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_step  (last_step),
        .sec_field  (opt_q[1:0]),
        .key_en     (opt_q[KEYEN_BIT]),
        .erase_done (erase_done),
        .key_done   (key_done),
        .key_match  (key_match),
        .key_wr     (key_wr),
        .key_dbg    (key_dbg),
        .fetch      (fetch),
        .capture    (capture),
        .boot_done  (boot_done),
        .secure     (secure),
        .accept     (accept)
    );

endmodule

// File: rtl/fsc_sva.sv
module fsc_sva #(
    parameter int unsigned KEY_LEN = 8,
    localparam int unsigned CNT_W  = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boot_done,
    input logic             secure,
    input logic             erase_done,
    input logic             key_wr,
    input logic             key_dbg,
    input logic [7:0]       opt_q,
    input logic [CNT_W-1:0] key_cnt
);
    import fsc_pkg::*;

    AST_SECURE_IN_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> secure);                                              // R4
    AST_BOOT_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_done) |-> (secure == (opt_q[1:0] == SEC_CODE)));          // R4
    AST_KEY_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && secure && !opt_q[KEYEN_BIT] && !erase_done) |=> secure); // R8
    AST_DEBUG_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_dbg) |=> $stable(key_cnt));                           // R7
    AST_ERASE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && erase_done) |=> !secure);                              // R9
    AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && !secure) |=> (!secure && boot_done));                  // R11

endmodule

bind flash_sec_ctrl fsc_sva #(.KEY_LEN(KEY_LEN)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_done  (boot_done),
    .secure     (secure),
    .erase_done (erase_done),
    .key_wr     (key_wr),
    .key_dbg    (key_dbg),
    .opt_q      (opt_q),
    .key_cnt    (key_cnt)
);

// File: tb/flash_sec_ctrl_test.sv
`timescale 1ns/1ps
module flash_sec_ctrl_test;

    localparam logic [15:0] BASE = 16'hFF80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = 8'h00;
    logic        key_wr = 1'b0;
    logic        key_dbg = 1'b0;
    logic [7:0]  key_data = 8'h00;
    logic        erase_done = 1'b0;
    logic        boot_done, secure;
    logic [7:0]  prot_q, opt_q, trim_q, ftrim_q;

    int checks = 0;
    int errors = 0;

    logic [7:0] nv [12];
    logic [7:0] kbuf [8];

    always #10 clk = ~clk;

    flash_sec_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .key_wr(key_wr), .key_dbg(key_dbg), .key_data(key_data),
        .erase_done(erase_done), .boot_done(boot_done), .secure(secure),
        .prot_q(prot_q), .opt_q(opt_q), .trim_q(trim_q), .ftrim_q(ftrim_q)
    );

    logic [15:0] ofs;
    assign ofs = rd_addr - BASE;
    always @(posedge clk) if (rd_en) rd_data <= nv[ofs[3:0]];

    function automatic logic exp_boot_secure(input logic [7:0] opt);
        return opt[1:0] == 2'b01;
    endfunction

    function automatic logic [7:0] exp_trim(input logic dbg, input logic [7:0] stored);
        return dbg ? 8'h80 : stored;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_nv(input logic [7:0] ft, input logic [7:0] tr,
                          input logic [7:0] pr, input logic [7:0] op);
        for (int i = 0; i < 8; i++) nv[i] = 8'($urandom);
        nv[8] = ft; nv[9] = tr; nv[10] = pr; nv[11] = op;
    endtask

    task automatic do_reset(input logic dbg);
        @(negedge clk);
        rst_n = 1'b0; dbg_mode = dbg;
        repeat (3) @(negedge clk);
        chk("R4 reset secure", {31'b0, secure}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 boot secure", {31'b0, secure}, 32'd1);
        for (int n = 0; n < 60 && !boot_done; n++) @(negedge clk);
        chk("R1 boot_done", {31'b0, boot_done}, 32'd1);
        @(negedge clk);
    endtask

    // mode 0 correct key, 1 wrong key; erase_last raises erase_done with the eighth byte
    task automatic enter_key(input int mode, input logic dbg, input logic erase_last);
        int bad;
        for (int i = 0; i < 8; i++) kbuf[i] = nv[i];
        if (mode == 1) begin
            bad = int'($urandom_range(7, 0));
            kbuf[bad] = kbuf[bad] ^ (8'($urandom_range(255, 1)));
        end
        for (int i = 0; i < 8; i++) begin
            key_wr = 1'b1; key_dbg = dbg; key_data = kbuf[i];
            erase_done = erase_last && (i == 7);
            @(negedge clk);
        end
        key_wr = 1'b0; key_dbg = 1'b0; erase_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_erase();
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd5150);

        // Scenario A: normal mode, secure, key enabled
        set_nv(8'hF3, 8'h5A, 8'h3C, 8'h81);
        do_reset(1'b0);
        chk("R1 prot_q", {24'b0, prot_q}, {24'b0, nv[10]});
        chk("R1 opt_q", {24'b0, opt_q}, {24'b0, nv[11]});
        chk("R2 trim normal", {24'b0, trim_q}, 32'h5A);
        chk("R3 ftrim", {24'b0, ftrim_q}, 32'h01);
        chk("R4 secure after boot", {31'b0, secure}, 32'd1);
        enter_key(0, 1'b1, 1'b0);
        chk("R7 debug key ignored", {31'b0, secure}, 32'd1);
        enter_key(0, 1'b0, 1'b0);
        chk("R5 correct key opens", {31'b0, secure}, 32'd0);
        enter_key(1, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        chk("R11 open sticky", {31'b0, secure}, 32'd0);

        // Scenario B: debug mode, wrong key then lockout
        set_nv(8'h02, 8'hC7, 8'h11, 8'h81);
        do_reset(1'b1);
        chk("R2 trim debug", {24'b0, trim_q}, 32'h80);
        chk("R3 ftrim zero", {24'b0, ftrim_q}, 32'h00);
        enter_key(1, 1'b0, 1'b0);
        chk("R6 wrong key", {31'b0, secure}, 32'd1);
        enter_key(0, 1'b0, 1'b0);
        chk("R6 lockout", {31'b0, secure}, 32'd1);
        pulse_erase();
        chk("R9 erase after lockout", {31'b0, secure}, 32'd0);

        // Scenario C: key disabled
        set_nv(8'h01, 8'h33, 8'h00, 8'h01);
        do_reset(1'b0);
        chk("R4 secure keyoff", {31'b0, secure}, 32'd1);
        enter_key(0, 1'b0, 1'b0);
        chk("R8 key disabled", {31'b0, secure}, 32'd1);
        pulse_erase();
        chk("R9 erase keyoff", {31'b0, secure}, 32'd0);

        // Scenario D: other encodings unsecure
        set_nv(8'h00, 8'h44, 8'h00, 8'h83);
        do_reset(1'b0);
        chk("R4 code 11 unsecure", {31'b0, secure}, 32'd0);
        set_nv(8'h00, 8'h44, 8'h00, 8'h00);
        do_reset(1'b0);
        chk("R4 code 00 unsecure", {31'b0, secure}, 32'd0);

        // Scenario E: erase coinciding with eighth byte
        set_nv(8'h00, 8'h10, 8'h00, 8'h81);
        do_reset(1'b0);
        enter_key(1, 1'b0, 1'b1);
        chk("R10 erase with wrong key", {31'b0, secure}, 32'd0);
        repeat (5) @(negedge clk);
        chk("R11 stays open", {31'b0, secure}, 32'd0);
        do_reset(1'b0);
        enter_key(0, 1'b0, 1'b1);
        chk("R10 erase with good key", {31'b0, secure}, 32'd0);

        // Random scenarios
        for (int it = 0; it < 24; it++) begin
            logic [7:0] op, tr, ft;
            logic       dbg, exp_sec;
            int         kind;
            op = 8'($urandom); tr = 8'($urandom); ft = 8'($urandom);
            if ($urandom_range(1, 0) == 1) op[1:0] = 2'b01;
            dbg  = 1'($urandom);
            kind = int'($urandom_range(2, 0));
            set_nv(ft, tr, 8'($urandom), op);
            do_reset(dbg);
            chk("R2 trim random", {24'b0, trim_q}, {24'b0, exp_trim(dbg, tr)});
            chk("R3 ftrim random", {24'b0, ftrim_q}, {31'b0, ft[0]});
            chk("R4 secure random", {31'b0, secure}, {31'b0, exp_boot_secure(op)});
            if (kind == 2) enter_key(0, 1'b1, 1'b0);
            else           enter_key(kind, 1'b0, 1'b0);
            exp_sec = exp_boot_secure(op) && !(op[7] && kind == 0);
            chk("R5/R6/R7/R8 random attempt", {31'b0, secure}, {31'b0, exp_sec});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule